// File: doc/BRIEF.md
# Amplifier Power-Mode Sequencer

This block turns two level inputs, a supply-good flag and a play request, into the two control levels that hold a speaker amplifier in standby and keep its speaker outputs muted (speaker save). The two levels change only in an order that avoids audible pops. A host reads the two levels and forwards them to the amplifier over its control bus. While both controls are asserted the amplifier is silent and draws no bias current. On the way up, standby is released first. Speaker save is released only after a precharge interval, measured in milliseconds, has passed so that the internal bias can settle. On the way down, both controls are asserted together in the same clock edge.

The supply-good flag is accepted only after it has stayed high without a break for a settling time in milliseconds. A drop of the flag forces both controls asserted in the same clock cycle and makes the block settle the supply again before it acts. A busy output shows that a transition is in progress: either the supply is being qualified or the precharge wait is running. A play request that is held while the block is busy is acted on as soon as the block reaches the both-asserted idle state. Removing the request during the precharge wait cancels the wait.

Both inputs must already be synchronous to `clk`. The clock frequency and both millisecond intervals are parameters, and the block converts them to clock counts.

Top module: `amp_power_sequencer`

## Requirements
- R1: After reset with supply-good low, `standby_o` = 1, `spk_save_o` = 1 and `busy_o` = 0.
- R2: The supply counts as qualified only after `supply_good_i` has been high on SETTLE_CYC = SETTLE_MS·CLK_HZ/1000 consecutive rising edges. One low cycle restarts the count. `busy_o` is 1 while the flag is high and the supply is not yet qualified. The block reaches the idle state on the next edge after qualification.
- R3: In the idle state (qualified, both controls 1) with `play_req_i` low, the outputs stay at `standby_o` = 1, `spk_save_o` = 1 and `busy_o` = 0.
- R4: When `play_req_i` is high in the idle state, the next edge sets `standby_o` to 0 and `busy_o` to 1, with `spk_save_o` still 1. `spk_save_o` falls, and `busy_o` falls with it, exactly PRECH_CYC + 1 edges after `standby_o` fell, where PRECH_CYC = PRECHARGE_MS·CLK_HZ/1000.
- R5: If `play_req_i` is low on an edge during the precharge wait, that edge sets both controls to 1 and `busy_o` to 0. Speaker save is not released afterwards, and a new request starts a full new wait.
- R6: With both controls released, a low `play_req_i` sets `standby_o` and `spk_save_o` to 1 on the same edge.
- R7: While `supply_good_i` is low, `standby_o` and `spk_save_o` are 1 and `busy_o` is 0 in that same cycle, from any state. The next edge returns the block to the unqualified state.
- R8: A play request held high through supply qualification is serviced without being raised again. `standby_o` falls one edge after the idle state is reached.
- R9: `spk_save_o` is never 0 while `standby_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_good_i | input | 1 | Amplifier supplies present (synchronous level) |
| play_req_i | input | 1 | Host wants the speakers active (level) |
| standby_o | output | 1 | Standby control level, 1 = standby on |
| spk_save_o | output | 1 | Speaker-save control level, 1 = outputs muted |
| busy_o | output | 1 | Supply qualification or precharge wait in progress |

## Verification
The main bring-up is driven in three ways: from an already-qualified idle state, with the request held through supply qualification, and again right after a cancelled wait. These separate an off-by-one in the precharge count from a counter that fails to restart, and from a request that gets lost while busy. A one-cycle supply glitch during qualification shows whether the settle count really restarts. Supply loss is applied both in the fully-on state and in the middle of the precharge wait, and the outputs are checked in the same cycle. This shows whether the forced assertion is combinational and whether the block requalifies the supply before it releases standby again.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,   // supply not yet qualified
        SEQ_IDLE  = 2'd1,   // qualified, both controls asserted
        SEQ_PRECH = 2'd2,   // standby released, waiting for bias
        SEQ_ON    = 2'd3    // both controls released
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       standby;
        logic       save;
    } seq_regs_t;

endpackage

// File: rtl/seq_cycle_delay.sv
module seq_cycle_delay #(
    parameter int unsigned CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    generate
        if (CYCLES == 0) begin : g_zero
            assign done_o = run_i;
        end else begin : g_count
            localparam int unsigned W = $clog2(CYCLES + 1);
            localparam logic [W-1:0] LIMIT = W'(CYCLES);

            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run_i) begin
                    cnt_d = '0;
                end else if (cnt_q != LIMIT) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign done_o = (cnt_q == LIMIT);

            AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LIMIT); // R2
            AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                !run_i |=> !done_o); // R2
        end
    endgenerate

endmodule

// File: rtl/amp_power_sequencer.sv
module amp_power_sequencer
    import amp_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 125_000_000,
    parameter int unsigned PRECHARGE_MS = 20,
    parameter int unsigned SETTLE_MS    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good_i,
    input  logic play_req_i,
    output logic standby_o,
    output logic spk_save_o,
    output logic busy_o
);

    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
    localparam int unsigned PRECH_CYC  = PRECHARGE_MS * CYC_PER_MS;
    localparam int unsigned SETTLE_CYC = SETTLE_MS * CYC_PER_MS;

    seq_regs_t cur_q, nxt_d;
    logic      supply_ok;
    logic      prech_done;
    logic      prech_run;

    assign prech_run = (cur_q.state == SEQ_PRECH);

    seq_cycle_delay #(.CYCLES(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (supply_good_i),
        .done_o (supply_ok)
    );

    seq_cycle_delay #(.CYCLES(PRECH_CYC)) u_precharge (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (prech_run),
        .done_o (prech_done)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!supply_good_i) begin
            nxt_d.state = SEQ_OFF;
        end else begin
            unique case (cur_q.state)
                SEQ_OFF:   if (supply_ok)       nxt_d.state = SEQ_IDLE;
                SEQ_IDLE:  if (play_req_i)      nxt_d.state = SEQ_PRECH;
                SEQ_PRECH: if (!play_req_i)     nxt_d.state = SEQ_IDLE;
                           else if (prech_done) nxt_d.state = SEQ_ON;
                SEQ_ON:    if (!play_req_i)     nxt_d.state = SEQ_IDLE;
                default:                        nxt_d.state = SEQ_OFF;
            endcase
        end
        nxt_d.standby = (nxt_d.state == SEQ_OFF) || (nxt_d.state == SEQ_IDLE);
        nxt_d.save    = (nxt_d.state != SEQ_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: SEQ_OFF, standby: 1'b1, save: 1'b1};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign standby_o  = cur_q.standby | ~supply_good_i;
    assign spk_save_o = cur_q.save    | ~supply_good_i;
    assign busy_o     = supply_good_i &
                        ((cur_q.state == SEQ_OFF) | (cur_q.state == SEQ_PRECH));

    AST_LOSS_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good_i |=> cur_q.state == SEQ_OFF); // R7
    AST_QUAL_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == SEQ_OFF) && !supply_ok |=> cur_q.state == SEQ_OFF); // R2
    AST_SAVE_AFTER_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !spk_save_o |-> !standby_o); // R9
    AST_RELEASE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spk_save_o) |-> $past(prech_run) && $past(prech_done)); // R4
    AST_DOWN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_o) |-> spk_save_o); // R6
    AST_ABORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        prech_run && !play_req_i |=> standby_o && spk_save_o && !busy_o); // R5

endmodule

// File: tb/tb_amp_power_sequencer.sv
module tb_amp_power_sequencer;

    localparam int unsigned CLK_HZ = 100_000;
    localparam int unsigned PMS    = 20;
    localparam int unsigned SMS    = 1;
    localparam int N = PMS * (CLK_HZ / 1000);
    localparam int S = SMS * (CLK_HZ / 1000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply = 1'b0;
    logic play = 1'b0;
    logic standby, save, busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    amp_power_sequencer #(
        .CLK_HZ(CLK_HZ), .PRECHARGE_MS(PMS), .SETTLE_MS(SMS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .supply_good_i(supply), .play_req_i(play),
        .standby_o(standby), .spk_save_o(save), .busy_o(busy)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected triple is {standby, save, busy}
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        #1;
        act = {standby, save, busy};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {standby,save,busy} actual %b expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; supply = 1'b0; play = 1'b0;
        step(3);
        chk("R1", 3'b110);
        rst_n = 1'b1;
        step(2);
        chk("R1", 3'b110);
    endtask

    task automatic t_qualify;
        supply = 1'b1;
        step(S - 10);
        chk("R2", 3'b111);
        supply = 1'b0;
        step(1);
        chk("R2", 3'b110);
        supply = 1'b1;
        step(S);
        chk("R2", 3'b111);
        step(1);
        chk("R2", 3'b110);
        step(20);
        chk("R3", 3'b110);
    endtask

    task automatic t_bringup;
        play = 1'b1;
        step(1);
        chk("R4", 3'b011);
        step(N);
        chk("R4", 3'b011);
        step(1);
        chk("R4", 3'b000);
        chk("R9", 3'b000);
    endtask

    task automatic t_shutdown;
        play = 1'b0;
        step(1);
        chk("R6", 3'b110);
        step(5);
        chk("R3", 3'b110);
    endtask

    task automatic t_abort;
        play = 1'b1;
        step(1);
        chk("R5", 3'b011);
        step(N / 2);
        play = 1'b0;
        step(1);
        chk("R5", 3'b110);
        step(N);
        chk("R5", 3'b110);
        play = 1'b1;
        step(1);
        chk("R5", 3'b011);
        step(N);
        chk("R5", 3'b011);
        step(1);
        chk("R5", 3'b000);
    endtask

    task automatic t_loss_on;
        supply = 1'b0;
        chk("R7", 3'b110);
        step(1);
        chk("R7", 3'b110);
        supply = 1'b1;
        step(S);
        chk("R8", 3'b111);
        step(1);
        chk("R8", 3'b110);
        step(1);
        chk("R8", 3'b011);
        step(N);
        step(1);
        chk("R8", 3'b000);
    endtask

    task automatic t_loss_prech;
        play = 1'b0;
        step(1);
        play = 1'b1;
        step(1);
        chk("R4", 3'b011);
        step(10);
        supply = 1'b0;
        chk("R7", 3'b110);
        step(1);
        supply = 1'b1;
        play = 1'b0;
        step(S + 1);
        chk("R7", 3'b110);
        step(5);
        chk("R3", 3'b110);
    endtask

    initial begin
        t_reset();
        t_qualify();
        t_bringup();
        t_shutdown();
        t_abort();
        t_loss_on();
        t_loss_prech();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200_000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule